// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block models the device side of a pipelined SDRAM read path: a few banks of column storage, a burst engine and an output stage that drives a data bus with an output enable. The controller presents a command each clock (no-op, read, write, precharge) with a bank, a column and an auto-close flag. The engine steps through the columns of the burst, and each beat's data passes through a delay line so that it reaches the bus after the configured CAS latency. The mask input blanks a beat two clocks after it is sampled. A write ends any read at once and releases the bus.

Burst length and CAS latency are static configuration inputs, changed only while no burst is running. Fixed bursts wrap inside their aligned block. A full-page burst runs around the whole page until a command stops it. Any new read replaces the running burst, so reads issued every clock give an unbroken stream of data. Locations never written return a fill pattern computed from their address, which lets a test know the expected data with no preload.

Top module: `sdram_read_path`

## Requirements
- R1: Commands are coded 0 no-op, 1 read, 2 write, 3 precharge. If a read is sampled at edge T, its first beat is on `dq_out` with `dq_oe` high from edge T+CL, where CL is `cfg_cas_lat` (2 or 3).
- R2: `cfg_burst` codes 0..3 select bursts of 1, 2, 4 and 8 beats. Beat k reads column base + ((start + k) mod N), where base is the start column rounded down to a multiple of N. Beats arrive on consecutive clocks.
- R3: `dq_oe` is low after reset. With no further command, it falls on the clock after the last beat of a burst.
- R4: `cfg_burst` codes 4..7 select a full-page burst. It reads start, start+1, ... and wraps from the last column to column 0. It continues until a read, write or precharge to its bank stops it.
- R5: A read that arrives during a burst replaces it. The beats issued before that read are still delivered, and the new burst's first beat follows the last of them on the next clock.
- R6: If `dqm` is high when sampled at edge T, the beat due from edge T+2 is suppressed (`dq_oe` low). Burst progress does not change.
- R7: A write sampled at edge T ends any running burst and discards every beat still in flight. `dq_oe` is low from edge T on.
- R8: A write stores `wr_data` at its bank and column only if `dqm` is low and `dq_oe` is low in that cycle; otherwise nothing is stored. An unwritten location reads as bank*4096 + ((col*3+5) mod 4096).
- R9: `bank_open[b]` is 0 after reset. A read or write to bank b sets it and a precharge to b clears it, both at the sampling edge. A precharge to the running burst's bank stops further beats.
- R10: When a burst with `cmd_autopre` set completes its last beat normally, its bank's `bank_open` bit clears on the edge after that beat is issued. This happens unless a read or write to that bank arrives at the same edge.
- R11: A read can be accepted on every clock. Back-to-back reads give one beat per clock with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_burst | input | 3 | Burst length code |
| cmd | input | 2 | Command code |
| cmd_bank | input | 2 | Bank address |
| cmd_col | input | 6 | Column address |
| cmd_autopre | input | 1 | Close the bank when this read completes |
| dqm | input | 1 | Data mask |
| wr_data | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Drive enable for read data |
| bank_open | output | 4 | Per-bank open-row state |

## Verification
A wrong burst index or base shows up as a wrong word on `dq_out` CL clocks after the faulty step. A miscounted end shows up as `dq_oe` staying high, or dropping early, at the burst's tail. A pipeline stage that is off by one moves every beat by a clock, so the very first beat of each read reveals it. An error in mask delay or flushing shows up as a single bad `dq_oe` cycle next to a `dqm` pulse or a write. Bank-state faults appear on `bank_open` one edge after the command or the final beat. The bench's behavioural model predicts every one of these signals on every clock.

// File: rtl/sdram_rp_pkg.sv
package sdram_rp_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;

  // Beats in a fixed burst; 0 means full page.
  function automatic int unsigned beats_of(logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return 0;
    endcase
  endfunction

  // Column of beat idx for a burst starting at start.
  function automatic int unsigned beat_col(int unsigned start, int unsigned idx,
                                           logic [2:0] code, int unsigned cols);
    int unsigned n;
    n = beats_of(code);
    if (n == 0) return (start + idx) % cols;
    return (start & ~(n - 1)) | ((start + idx) & (n - 1));
  endfunction

  // Content of a location never written.
  function automatic logic [31:0] fill_word(int unsigned bank, int unsigned col);
    return 32'((bank << 12) | ((col * 3 + 5) & 32'hFFF));
  endfunction

endpackage

// File: rtl/sdram_burst_ctl.sv
module sdram_burst_ctl
  import sdram_rp_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COLS  = 64,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [CW-1:0]    cmd_col,
  input  logic             cmd_autopre,
  input  logic [2:0]       cfg_burst,
  output logic             iss_vld,
  output logic [BW-1:0]    iss_bank,
  output logic [CW-1:0]    iss_col,
  output logic [NBANK-1:0] bank_open
);

  logic            act;
  logic [BW-1:0]   b_bank;
  logic [CW-1:0]   b_start, b_idx;
  logic [2:0]      b_code;
  logic            b_ap;

  int unsigned     nbeats;
  logic            fixed_mode, last_beat, stop_pre, ap_close, opens;
  logic [NBANK-1:0] open_nxt;

  always_comb begin
    nbeats     = beats_of(b_code);
    fixed_mode = (nbeats != 0);
    last_beat  = act && fixed_mode && (32'(b_idx) == nbeats - 1);
    stop_pre   = (cmd == CMD_PRE) && (cmd_bank == b_bank);
    ap_close   = last_beat && b_ap;
    opens      = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  end

  assign iss_vld  = act;
  assign iss_bank = b_bank;
  assign iss_col  = CW'(beat_col(32'(b_start), 32'(b_idx), b_code, COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      b_bank  <= '0;
      b_start <= '0;
      b_idx   <= '0;
      b_code  <= '0;
      b_ap    <= 1'b0;
    end else if (cmd == CMD_READ) begin
      act     <= 1'b1;
      b_bank  <= cmd_bank;
      b_start <= cmd_col;
      b_idx   <= '0;
      b_code  <= cfg_burst;
      b_ap    <= cmd_autopre;
    end else if (cmd == CMD_WRITE || stop_pre || last_beat) begin
      act     <= 1'b0;
    end else if (act) begin
      b_idx   <= b_idx + 1'b1;
    end
  end

  always_comb begin
    open_nxt = bank_open;
    if (ap_close)       open_nxt[b_bank]   = 1'b0;
    if (cmd == CMD_PRE) open_nxt[cmd_bank] = 1'b0;
    if (opens)          open_nxt[cmd_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bank_open <= '0;
    else        bank_open <= open_nxt;
  end

  p_fixed_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && fixed_mode) |-> (32'(b_idx) < nbeats));

  p_write_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRITE) |=> !act);

  p_pre_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pre && act) |=> !act);

  p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |=> !bank_open[$past(cmd_bank)]);

  p_ap_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_close && !(opens && cmd_bank == b_bank)) |=> !bank_open[$past(b_bank)]);

endmodule

// File: rtl/sdram_cell_array.sv
module sdram_cell_array
  import sdram_rp_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COLS  = 64,
  parameter int DW    = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(COLS),
  localparam int DEPTH = NBANK * COLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_bank,
  input  logic [CW-1:0] wr_col,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] rd_bank,
  input  logic [CW-1:0] rd_col,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [BW+CW-1:0] wa, ra;

  assign wa = {wr_bank, wr_col};
  assign ra = {rd_bank, rd_col};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     written     <= '0;
    else if (wr_en) written[wa] <= 1'b1;
  end

  assign rd_data = written[ra] ? mem[ra]
                               : DW'(fill_word(32'(rd_bank), 32'(rd_col)));

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (written[$past(wa)] && mem[$past(wa)] == $past(wr_data)));

endmodule

// File: rtl/sdram_out_pipe.sv
module sdram_out_pipe #(
  parameter int DW    = 16,
  parameter int MAXCL = 3,
  localparam int STG  = MAXCL - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_cas_lat,
  input  logic          iss_vld,
  input  logic [DW-1:0] iss_data,
  input  logic          dqm,
  input  logic          flush,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  logic          sv [STG];
  logic [DW-1:0] sd [STG];
  logic          dqm_d1, dqm_d2;
  int unsigned   tap;

  always_comb begin
    if (cfg_cas_lat < 2'd2)              tap = 0;
    else if (32'(cfg_cas_lat) > MAXCL)   tap = STG - 1;
    else                                 tap = 32'(cfg_cas_lat) - 2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < STG; i++) begin
        sv[i] <= 1'b0;
        sd[i] <= '0;
      end
    end else begin
      sv[0] <= iss_vld;
      sd[0] <= iss_data;
      for (int i = 1; i < STG; i++) begin
        sv[i] <= sv[i-1];
        sd[i] <= sd[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqm_d1 <= 1'b0;
      dqm_d2 <= 1'b0;
    end else begin
      dqm_d1 <= dqm;
      dqm_d2 <= dqm_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= sv[tap] && !dqm_d2;
      dq_out <= sd[tap];
    end
  end

  p_dqm_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(dqm, 3));

  p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !dq_oe);

  p_lat2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && cfg_cas_lat == 2'd2 && $past(cfg_cas_lat) == 2'd2) |-> $past(iss_vld, 2));

  p_lat3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && cfg_cas_lat == 2'd3 && $past(cfg_cas_lat) == 2'd3) |-> $past(iss_vld, 3));

endmodule

// File: rtl/sdram_read_path.sv
module sdram_read_path
  import sdram_rp_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COLS  = 64,
  parameter int DW    = 16,
  parameter int MAXCL = 3,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_cas_lat,
  input  logic [2:0]       cfg_burst,
  input  logic [1:0]       cmd,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [CW-1:0]    cmd_col,
  input  logic             cmd_autopre,
  input  logic             dqm,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic [NBANK-1:0] bank_open
);

  cmd_e          cmd_c;
  logic          iss_vld, wr_en, flush;
  logic [BW-1:0] iss_bank;
  logic [CW-1:0] iss_col;
  logic [DW-1:0] rd_data;

  assign cmd_c = cmd_e'(cmd);
  assign flush = (cmd_c == CMD_WRITE);
  assign wr_en = flush && !dqm && !dq_oe;

  sdram_burst_ctl #(.NBANK(NBANK), .COLS(COLS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_c), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_autopre(cmd_autopre), .cfg_burst(cfg_burst),
    .iss_vld(iss_vld), .iss_bank(iss_bank), .iss_col(iss_col),
    .bank_open(bank_open)
  );

  sdram_cell_array #(.NBANK(NBANK), .COLS(COLS), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(cmd_bank),
    .wr_col(cmd_col), .wr_data(wr_data), .rd_bank(iss_bank),
    .rd_col(iss_col), .rd_data(rd_data)
  );

  sdram_out_pipe #(.DW(DW), .MAXCL(MAXCL)) u_out (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
    .iss_vld(iss_vld), .iss_data(rd_data), .dqm(dqm), .flush(flush),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: tb/tb_sdram_read_path.sv
`timescale 1ns/1ps
module tb_sdram_read_path;

  localparam int NC = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_cas_lat;
  logic [2:0]  cfg_burst;
  logic [1:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [5:0]  cmd_col;
  logic        cmd_autopre;
  logic        dqm;
  logic [15:0] wr_data;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [3:0]  bank_open;

  sdram_read_path dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst(cfg_burst),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_autopre(cmd_autopre),
    .dqm(dqm), .wr_data(wr_data), .dq_out(dq_out), .dq_oe(dq_oe),
    .bank_open(bank_open)
  );

  always #4 clk = ~clk;

  int    nchk = 0;
  int    nerr = 0;
  string cur_req = "R9";
  bit    finished = 0;

  // reference model state
  int       cyc = 0;
  bit       ev [int];
  int       ed [int];
  bit       dh [int];
  int       memw [int];
  bit       m_act = 0;
  int       m_bank, m_start, m_idx, m_n;
  bit       m_ap;
  bit [3:0] exp_bo = '0;

  function automatic int ref_col(int start, int idx, int n);
    if (n == 0) return (start + idx) % NC;
    return (start / n) * n + ((start % n) + idx) % n;
  endfunction

  function automatic int ref_word(int b, int c);
    if (memw.exists(b * NC + c)) return memw[b * NC + c];
    return b * 4096 + ((c * 3 + 5) % 4096);
  endfunction

  function automatic int bl_n(int code);
    return (code < 4) ? (1 << code) : 0;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
               cur_req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int  c, o, cl;
    bit  cur_oe;
    cyc++;
    dh[cyc] = dqm;
    cl = int'(cfg_cas_lat);
    if (!rst_n) begin
      ev.delete();
      ed.delete();
      memw.delete();
      m_act  = 0;
      exp_bo = '0;
    end else begin
      cur_oe = ev.exists(cyc - 1) ? ev[cyc - 1] : 1'b0;
      if (m_act) begin
        c = ref_col(m_start, m_idx, m_n);
        o = cyc + cl - 1;
        ev[o] = !(dh.exists(o - 2) && dh[o - 2]);
        ed[o] = ref_word(m_bank, c);
        if (m_n != 0 && m_idx == m_n - 1) begin
          m_act = 0;
          if (m_ap) exp_bo[m_bank] = 1'b0;
        end else begin
          m_idx++;
        end
      end
      case (cmd)
        2'd2: begin
          foreach (ev[k]) if (k >= cyc) ev[k] = 1'b0;
          m_act = 0;
          if (!dqm && !cur_oe) memw[int'(cmd_bank) * NC + int'(cmd_col)] = int'(wr_data);
          exp_bo[cmd_bank] = 1'b1;
        end
        2'd1: begin
          m_act   = 1;
          m_bank  = int'(cmd_bank);
          m_start = int'(cmd_col);
          m_idx   = 0;
          m_n     = bl_n(int'(cfg_burst));
          m_ap    = cmd_autopre;
          exp_bo[cmd_bank] = 1'b1;
        end
        2'd3: begin
          exp_bo[cmd_bank] = 1'b0;
          if (m_act && m_bank == int'(cmd_bank)) m_act = 0;
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    bit e_v;
    if (rst_n && !finished) begin
      e_v = ev.exists(cyc) ? ev[cyc] : 1'b0;
      check(dq_oe == e_v, "dq_oe", int'(dq_oe), int'(e_v));
      if (e_v) check(int'(dq_out) == ed[cyc], "dq_out", int'(dq_out), ed[cyc]);
      check(bank_open == exp_bo, "bank_open", int'(bank_open), int'(exp_bo));
    end
  end

  task automatic drive(input int c, input int b, input int col, input bit ap, input int wd);
    cmd         = 2'(c);
    cmd_bank    = 2'(b);
    cmd_col     = 6'(col);
    cmd_autopre = ap;
    wr_data     = 16'(wd);
    @(negedge clk);
    cmd         = 2'd0;
    cmd_autopre = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_cas_lat = 2'd2; cfg_burst = 3'd2; cmd = 2'd0;
    cmd_bank = 0; cmd_col = 0; cmd_autopre = 0; dqm = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    cur_req = "R3"; check(dq_oe == 1'b0, "reset dq_oe", int'(dq_oe), 0);
    cur_req = "R9"; check(bank_open == 4'b0, "reset bank_open", int'(bank_open), 0);
    rst_n = 1;
    @(negedge clk);

    // CL2, burst of 4 from column 6: columns 6,7,4,5
    cur_req = "R1"; drive(1, 1, 6, 0, 0);
    cur_req = "R2"; idle(3);
    cur_req = "R3"; idle(4);

    // CL3, burst of 8 with auto close
    cfg_cas_lat = 2'd3; cfg_burst = 3'd3;
    cur_req = "R10"; drive(1, 2, 13, 1, 0); idle(12);

    // bursts of 1 and 2
    cfg_burst = 3'd0; cur_req = "R2"; drive(1, 3, 5, 0, 0); idle(5);
    cfg_burst = 3'd1; cur_req = "R10"; drive(1, 0, 9, 1, 0); idle(6);

    // full page with wrap; precharge to another bank does not stop it
    cfg_cas_lat = 2'd2; cfg_burst = 3'd7;
    cur_req = "R4"; drive(1, 1, 60, 0, 0); idle(6);
    cur_req = "R9"; drive(3, 3, 0, 0, 0); idle(3);
    drive(3, 1, 0, 0, 0); idle(5);

    // truncation by a new read
    cfg_burst = 3'd3;
    cur_req = "R5"; drive(1, 0, 0, 0, 0); idle(2); drive(1, 2, 20, 0, 0); idle(10);

    // reads every clock
    cfg_burst = 3'd2; cur_req = "R11";
    for (int i = 0; i < 6; i++) drive(1, i % 4, i * 7, 0, 0);
    idle(6);

    // mask pulses during a burst
    cfg_burst = 3'd3; cur_req = "R6";
    drive(1, 3, 40, 0, 0); idle(2);
    dqm = 1; idle(1); dqm = 0; idle(1); dqm = 1; idle(2); dqm = 0; idle(8);

    // idle writes, one masked, then read back
    cur_req = "R8";
    drive(2, 1, 7, 0, 16'hBEEF);
    dqm = 1; drive(2, 1, 8, 0, 16'h1234); dqm = 0; idle(2);
    drive(1, 1, 4, 0, 0); idle(6);
    cfg_burst = 3'd1; drive(1, 1, 8, 0, 0); idle(5);

    // write while read data is on the bus
    cfg_burst = 3'd3; cur_req = "R7";
    drive(1, 2, 0, 0, 0); idle(3); drive(2, 2, 3, 0, 16'hCAFE); idle(6);
    cfg_burst = 3'd0; cur_req = "R8"; drive(1, 2, 3, 0, 0); idle(5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule